// File: doc/BRIEF.md
# Indexed Palette Colour Map with Component Register Port

This block keeps the colour map of an indexed-colour display: 256 pixel colours and four overlay colours, each stored as 8-bit red, green and blue. A processor reaches it through a small 32-bit register window. It first loads an entry number. It then moves colour bytes one at a time in red, green, blue order. After every third byte the entry number advances by itself, so a whole palette can be loaded with one index write followed by a stream of data writes.

The overlay entries share the index register. An overlay access uses only the two low index bits and selects one of the four entries that sit above the pixel entries, at entry numbers 256 to 259. Reads walk through the same three-step component sequence as writes.

A second port, which only reads, serves a pixel pipeline. It takes a 9-bit entry number and returns the packed 24-bit colour of that entry one clock later.

Top module: `palette_dac_port`

## Requirements
- R1: After reset, every entry reads as black (0x000000) except entries 255, 256 and 258, which read as white (0xFFFFFF). The index and the component phase are both zero, and `rdata` is zero.
- R2: A write to byte offset 0x0 loads the index from `wdata[31:24]` and returns the phase to red.
- R3: A write to offset 0x4 stores `wdata[31:24]` into one component of pixel entry [index]. Successive writes fill red, then green, then blue.
- R4: A write to offset 0xC stores into overlay entry 256 + (index & 3) and follows the same red, green, blue sequence.
- R5: The phase only ever takes the values red (0), green (1) and blue (2). A data access made in the blue phase returns the phase to red and increments the index modulo 256, so index 255 wraps to 0.
- R6: A read at offset 0x4 (pixel entry) or 0xC (overlay entry) puts the current component in `rdata[31:24]` with bits 23:0 at zero, one clock after the request. It then advances the phase exactly as a data write does.
- R7: Writes to any offset other than 0x0, 0x4 and 0xC change neither the colours, nor the index, nor the phase.
- R8: Reads from offsets other than 0x4 and 0xC return zero one clock later and do not advance the phase.
- R9: `lk_color` returns {R,G,B} of entry `lk_idx` one clock later. Entry numbers 260 to 511 return zero. A lookup made in the same cycle as a write to the same entry returns the old colour.
- R10: When `wr_en` and `rd_en` are both high, only the write is performed: `rdata` keeps its previous value and the read does not advance the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset inside the 16-byte window |
| wdata | input | 32 | Write data; the byte is taken from bits 31:24 |
| rdata | output | 32 | Read data, registered; the component is in bits 31:24 |
| lk_idx | input | 9 | Entry number for the pixel lookup |
| lk_color | output | 24 | Looked-up colour {R,G,B}, registered |

## Verification
Register reads and lookups both deliver their result in the cycle after the request, because each passes through exactly one register. The bench drives its stimulus on the falling edge. For every read or lookup, the driver puts the expected word into a queue at that moment. A monitor notes at the next rising edge that a result is due, and pops and compares the queue entry at the following falling edge. Index, phase and colour changes have no direct output, so the bench shows them through later reads and lookups. These include a lookup that shares its cycle with a write, and a read that shares its cycle with a write; both must see the state from before the write.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
    localparam int PIX_ENTRIES = 256;
    localparam int OVL_ENTRIES = 4;
    localparam int ENTRIES     = PIX_ENTRIES + OVL_ENTRIES;
    localparam int COMP_W      = 8;
    localparam int IDX_W       = $clog2(PIX_ENTRIES);
    localparam int ENT_W       = $clog2(ENTRIES);
    localparam int OVL_W       = $clog2(OVL_ENTRIES);
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int BYTE_LSB    = DATA_W - COMP_W;

    localparam logic [ADDR_W-1:0] OFF_INDEX = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_PIX   = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_OVL   = 4'hC;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    function automatic rgb_t reset_color(input int unsigned ent);
        rgb_t c;
        if (ent == 255 || ent == 256 || ent == 258) c = '1;
        else c = '0;
        return c;
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] pick_comp(input rgb_t c, input phase_e p);
        case (p)
            PH_RED:   return c.r;
            PH_GREEN: return c.g;
            default:  return c.b;
        endcase
    endfunction
endpackage

// File: rtl/pal_regif.sv
`timescale 1ns/1ps
module pal_regif
    import pal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [COMP_W-1:0]    wbyte,
    input  rgb_t                 cur_color,
    output logic [ENT_W-1:0]     cur_ent,
    output logic                 st_we,
    output phase_e               st_phase,
    output logic [COMP_W-1:0]    st_val,
    output logic [DATA_W-1:0]    rdata,
    output logic [IDX_W-1:0]     index_o,
    output phase_e               phase_o
);
    logic [IDX_W-1:0] idx_q;
    phase_e           ph_q;
    logic             is_ovl;
    logic             is_data;
    logic             do_wr_idx;
    logic             do_wr_data;
    logic             do_rd;
    logic             step;

    assign is_ovl  = (addr == OFF_OVL);
    assign is_data = (addr == OFF_PIX) || is_ovl;

    // overlay selects 256 + low index bits; pixel uses the full index
    assign cur_ent = is_ovl
        ? ENT_W'(PIX_ENTRIES + int'(idx_q[OVL_W-1:0]))
        : ENT_W'(idx_q);

    assign do_wr_idx  = wr_en && (addr == OFF_INDEX);
    assign do_wr_data = wr_en && is_data;
    assign do_rd      = rd_en && !wr_en;
    assign step       = do_wr_data || (do_rd && is_data);

    assign st_we    = do_wr_data;
    assign st_phase = ph_q;
    assign st_val   = wbyte;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ph_q  <= PH_RED;
        end else if (do_wr_idx) begin
            idx_q <= wbyte;
            ph_q  <= PH_RED;
        end else if (step) begin
            ph_q <= next_phase(ph_q);
            if (ph_q == PH_BLUE) idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (do_rd) begin
            if (is_data) rdata <= {pick_comp(cur_color, ph_q), {BYTE_LSB{1'b0}}};
            else         rdata <= '0;
        end
    end

    assign index_o = idx_q;
    assign phase_o = ph_q;
endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ENT_W-1:0]  w_ent,
    input  phase_e            w_phase,
    input  logic [COMP_W-1:0] w_val,
    output rgb_t              w_cur,
    input  logic [ENT_W-1:0]  lk_ent,
    output rgb_t              lk_color
);
    rgb_t ents [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        rgb_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= reset_color(e);
            end else if (we && (w_ent == ENT_W'(e))) begin
                case (w_phase)
                    PH_RED:   q.r <= w_val;
                    PH_GREEN: q.g <= w_val;
                    default:  q.b <= w_val;
                endcase
            end
        end
        assign ents[e] = q;
    end

    assign w_cur = (int'(w_ent) < ENTRIES) ? ents[w_ent] : '0;

    always_ff @(posedge clk) begin
        if (rst)                         lk_color <= '0;
        else if (int'(lk_ent) < ENTRIES) lk_color <= ents[lk_ent];
        else                             lk_color <= '0;
    end
endmodule

// File: rtl/palette_dac_port.sv
`timescale 1ns/1ps
module palette_dac_port
    import pal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [ENT_W-1:0]     lk_idx,
    output logic [3*COMP_W-1:0]  lk_color
);
    logic [ENT_W-1:0]  cur_ent;
    logic              st_we;
    phase_e            st_phase;
    logic [COMP_W-1:0] st_val;
    rgb_t              cur_color;
    rgb_t              lk_rgb;
    logic [IDX_W-1:0]  idx_w;
    phase_e            phase_w;
    logic              unused_low;

    assign unused_low = &{1'b0, wdata[BYTE_LSB-1:0]};

    pal_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wbyte     (wdata[DATA_W-1:BYTE_LSB]),
        .cur_color (cur_color),
        .cur_ent   (cur_ent),
        .st_we     (st_we),
        .st_phase  (st_phase),
        .st_val    (st_val),
        .rdata     (rdata),
        .index_o   (idx_w),
        .phase_o   (phase_w)
    );

    pal_store u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (st_we),
        .w_ent    (cur_ent),
        .w_phase  (st_phase),
        .w_val    (st_val),
        .w_cur    (cur_color),
        .lk_ent   (lk_idx),
        .lk_color (lk_rgb)
    );

    assign lk_color = lk_rgb;
endmodule

// File: rtl/pal_dac_checker.sv
`timescale 1ns/1ps
module pal_dac_checker
    import pal_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [COMP_W-1:0]   wbyte,
    input logic [DATA_W-1:0]   rdata,
    input logic [ENT_W-1:0]    lk_idx,
    input logic [3*COMP_W-1:0] lk_color,
    input logic [IDX_W-1:0]    index,
    input logic [1:0]          phase
);
    logic data_off;
    assign data_off = (addr == OFF_PIX) || (addr == OFF_OVL);

    AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[BYTE_LSB-1:0] == '0); // R6

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3); // R5

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_INDEX) |=> (index == $past(wbyte) && phase == 2'd0)); // R2

    AST_BLUE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && data_off && phase == 2'd2) |=> (phase == 2'd0 && index == $past(index) + 1'b1)); // R5

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !data_off) |=> (rdata == '0 && $stable(phase) && $stable(index))); // R8

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !data_off && addr != OFF_INDEX) |=> ($stable(phase) && $stable(index))); // R7

    AST_WR_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(rdata)); // R10

    AST_LOOKUP_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(lk_idx) >= ENTRIES) |=> (lk_color == '0)); // R9
endmodule

bind palette_dac_port pal_dac_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wbyte    (wdata[31:24]),
    .rdata    (rdata),
    .lk_idx   (lk_idx),
    .lk_color (lk_color),
    .index    (idx_w),
    .phase    (phase_w)
);

// File: tb/palette_dac_port_bench.sv
`timescale 1ns/1ps
module palette_dac_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  lk_idx = '0;
    logic [23:0] lk_color;
    logic        lk_req = 1'b0;

    always #2 clk = ~clk;

    palette_dac_port u_palette_dac_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lk_idx(lk_idx), .lk_color(lk_color)
    );

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t rd_q[$];
    item_t lk_q[$];

    int checks = 0;
    int fails  = 0;

    // reference state of the colour map
    logic [7:0]  mr [260];
    logic [7:0]  mg [260];
    logic [7:0]  mb [260];
    logic [7:0]  m_idx;
    int          m_ph;
    logic [31:0] m_last;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ent_of(input logic [3:0] a);
        if (a == 4'hC) return 256 + int'(m_idx[1:0]);
        return int'(m_idx);
    endfunction

    function automatic void advance();
        if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
        else m_ph = m_ph + 1;
    endfunction

    task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d,
                      input logic l, input logic [8:0] li, input string tag);
        item_t it;
        int e;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = {d, 24'h5A5A5A};
        lk_req = l; lk_idx = li;
        if (l) begin
            it.tag = tag;
            it.exp = (int'(li) < 260) ? {8'h00, mr[li], mg[li], mb[li]} : 32'h0;
            lk_q.push_back(it);
        end
        if (r) begin
            it.tag = tag;
            if (w) it.exp = m_last;
            else if (a == 4'h4 || a == 4'hC) begin
                e = ent_of(a);
                it.exp = {(m_ph == 0) ? mr[e] : (m_ph == 1) ? mg[e] : mb[e], 24'h0};
                advance();
            end else it.exp = 32'h0;
            m_last = it.exp;
            rd_q.push_back(it);
        end
        if (w) begin
            if (a == 4'h0) begin m_idx = d; m_ph = 0; end
            else if (a == 4'h4 || a == 4'hC) begin
                e = ent_of(a);
                if (m_ph == 0) mr[e] = d; else if (m_ph == 1) mg[e] = d; else mb[e] = d;
                advance();
            end
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
        op(1'b1, 1'b0, a, d, 1'b0, 9'd0, tag);
    endtask
    task automatic rd(input logic [3:0] a, input string tag);
        op(1'b0, 1'b1, a, 8'h00, 1'b0, 9'd0, tag);
    endtask
    task automatic lk(input logic [8:0] li, input string tag);
        op(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, li, tag);
    endtask
    task automatic idle();
        op(1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 9'd0, "");
    endtask

    // monitor: a request seen at a rising edge is compared at the next falling edge
    logic rd_due = 1'b0;
    logic lk_due = 1'b0;
    always @(posedge clk) begin
        rd_due <= rd_en && !rst;
        lk_due <= lk_req && !rst;
    end
    always @(negedge clk) begin
        item_t it;
        if (rd_due) begin
            if (rd_q.size() == 0) check(rdata, 32'hDEAD_0000, "rd queue empty");
            else begin it = rd_q.pop_front(); check(rdata, it.exp, it.tag); end
        end
        if (lk_due) begin
            if (lk_q.size() == 0) check({8'h00, lk_color}, 32'hDEAD_0000, "lk queue empty");
            else begin it = lk_q.pop_front(); check({8'h00, lk_color}, it.exp, it.tag); end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 260; i++) begin
            mr[i] = (i == 255 || i == 256 || i == 258) ? 8'hFF : 8'h00;
            mg[i] = mr[i];
            mb[i] = mr[i];
        end
        m_idx = '0; m_ph = 0; m_last = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(rdata, 32'h0, "R1 rdata after reset");

        // R1 reset colours, R9 range
        lk(9'd0, "R1 entry 0 black");
        lk(9'd100, "R1 entry 100 black");
        lk(9'd255, "R1 entry 255 white");
        lk(9'd256, "R1 entry 256 white");
        lk(9'd257, "R1 entry 257 black");
        lk(9'd258, "R1 entry 258 white");
        lk(9'd259, "R1 entry 259 black");
        lk(9'd300, "R9 out of range zero");
        lk(9'd511, "R9 top entry number zero");
        rd(4'h4, "R1 R6 read red of entry 0");
        rd(4'h4, "R6 read green");
        rd(4'h4, "R6 read blue");

        // R2 R3 pixel write and read back
        wr(4'h0, 8'h10, "R2 load index");
        wr(4'h4, 8'h11, "R3 red");
        wr(4'h4, 8'h22, "R3 green");
        wr(4'h4, 8'h33, "R3 blue");
        lk(9'd16, "R3 entry 16 colour");
        wr(4'h0, 8'h10, "R2 reload index");
        rd(4'h4, "R6 readback red");
        rd(4'h4, "R6 readback green");
        rd(4'h4, "R6 readback blue");
        rd(4'h4, "R5 index advanced after blue read");

        // R5 index wrap
        wr(4'h0, 8'hFF, "R2 index 255");
        wr(4'h4, 8'hAA, "R3"); wr(4'h4, 8'hBB, "R3"); wr(4'h4, 8'hCC, "R3");
        wr(4'h4, 8'h01, "R5"); wr(4'h4, 8'h02, "R5"); wr(4'h4, 8'h03, "R5");
        lk(9'd255, "R3 entry 255 written");
        lk(9'd0, "R5 wrap wrote entry 0");

        // R4 overlay
        wr(4'h0, 8'h06, "R2");
        wr(4'hC, 8'h44, "R4"); wr(4'hC, 8'h55, "R4"); wr(4'hC, 8'h66, "R4");
        lk(9'd258, "R4 overlay entry 258");
        lk(9'd6, "R4 pixel entry 6 untouched");
        rd(4'hC, "R4 overlay 259 red"); rd(4'hC, "R4 overlay 259 green"); rd(4'hC, "R4 overlay 259 blue");
        wr(4'h0, 8'h06, "R2");
        rd(4'hC, "R4 overlay 258 red"); rd(4'hC, "R4 overlay 258 green"); rd(4'hC, "R4 overlay 258 blue");

        // R7 ignored offsets
        wr(4'h0, 8'h20, "R2");
        wr(4'h4, 8'h77, "R7");
        wr(4'h8, 8'h99, "R7 offset 8 ignored");
        wr(4'h1, 8'h99, "R7 offset 1 ignored");
        wr(4'h5, 8'h99, "R7 offset 5 ignored");
        wr(4'h4, 8'h88, "R7"); wr(4'h4, 8'h99, "R7");
        lk(9'd32, "R7 entry 32 unaffected by ignored writes");
        lk(9'd33, "R7 entry 33 untouched");

        // R8 bad reads
        wr(4'h0, 8'h21, "R2");
        wr(4'h4, 8'h0A, "R3"); wr(4'h4, 8'h0B, "R3"); wr(4'h4, 8'h0C, "R3");
        wr(4'h0, 8'h21, "R2");
        rd(4'h8, "R8 offset 8 reads zero");
        rd(4'h4, "R8 phase kept red");
        rd(4'h0, "R8 offset 0 reads zero");
        rd(4'h4, "R8 phase kept green");

        // R10 simultaneous write and read
        wr(4'h0, 8'h21, "R2");
        rd(4'h4, "R10 prior read red");
        op(1'b1, 1'b1, 4'h4, 8'h5A, 1'b0, 9'd0, "R10 rdata held during write");
        rd(4'h4, "R10 read blue after write-only step");
        lk(9'd33, "R10 green overwritten");

        // R9 same-cycle write and lookup
        wr(4'h0, 8'h30, "R2");
        op(1'b1, 1'b0, 4'h4, 8'hDE, 1'b1, 9'd48, "R9 same-cycle lookup old value");
        lk(9'd48, "R9 lookup after write");

        idle();
        repeat (3) @(negedge clk);
        if (rd_q.size() != 0 || lk_q.size() != 0)
            check(32'(rd_q.size() + lk_q.size()), 32'h0, "R6 R9 results left unchecked");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule